// File: doc/BRIEF.md
# Counter Overflow Interrupt Unit

This block sits beside a bank of event counters and turns their one-cycle overflow pulses into a single level-sensitive interrupt. Each counter has one sticky pending bit and one enable bit. A pending bit is set by that counter's overflow pulse and stays set until software clears it. The interrupt line is high while at least one pending bit has its enable bit set.

Software reaches the unit through a simple single-cycle register port. A request is taken on any rising edge where `reg_req` is high, and `reg_we` chooses between a write and a read. There are five word offsets. Enable bits are turned on through one write-one-to-set offset and turned off through a separate write-one-to-clear offset, so neither write needs a read-modify-write. The enable mask and the pending mask can each be read back, and pending bits are cleared through a write-one-to-clear offset.

Counter n always appears at data bit BIT_BASE+n, which is bit 8+n by default, so bits 8 to 23 carry the sixteen counters. The bits below that field are kept for other interrupt sources and read as zero here. The bits above the field also read as zero.

The port has a two-state access machine. In `ACC_IDLE` no read data is being presented. When a read request arrives, the machine takes the `IDLE_TO_RESP` transition to `ACC_RESP`, and in that state `reg_rvalid` is high and the read data is held. From `ACC_RESP`, another read request takes `RESP_TO_RESP` and the machine stays there. Anything else takes `RESP_TO_IDLE` back to `ACC_IDLE`. Writes take effect at the edge that samples them and never enter `ACC_RESP`.

Top module: `ovf_irq_unit`

## Requirements
- R1: After reset, every enable bit and every pending bit is zero, `irq` is low and `reg_rvalid` is low.
- R2: A write to offset 0 (enable-set) with data bit 8+n at 1 enables counter n. Data bits at 0 leave the matching enable bits unchanged.
- R3: A write to offset 1 (enable-clear) with data bit 8+n at 1 disables counter n. Data bits at 0 leave the matching enable bits unchanged.
- R4: A read of offset 2 returns the enable mask, with counter n at bit 8+n. All other bits read 0, and writing any bit outside bits [23:8] has no effect.
- R5: An overflow pulse on `ovf_pulse[n]` sets pending bit n whatever the state of the enable mask. The pending mask is read at offset 4, with counter n at bit 8+n and all other bits 0.
- R6: A write to offset 3 (pending-clear) with data bit 8+n at 1 clears pending bit n. Data bits at 0 leave the matching pending bits set. Writing 0x00FFFFFF clears every pending bit.
- R7: If an overflow pulse and a pending-clear for the same counter arrive at the same edge, that pending bit is set after the edge.
- R8: `irq` is high exactly when some counter has both its pending bit and its enable bit set. It reflects the register state that follows the edge on which a pulse or write was sampled.
- R9: For a read, `reg_rvalid` is high for the cycle after the sampling edge. `reg_rdata` then carries the value the addressed register held before that edge. Offsets 5 to 7 read as zero. Writes to offsets 2, 4, 5, 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ovf_pulse | input | NUM_CNT | One overflow pulse per counter, sampled on each rising edge |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid while `reg_rvalid` is high |
| reg_rvalid | output | 1 | Read response valid, high for the cycle after a read is sampled |
| irq | output | 1 | Level interrupt output |

## Verification
Set-enable, clear-enable, pending-clear and overflow pulses all act on the rising edge that samples them. `irq` shows the result right after that same edge. Read data arrives one cycle later, with `reg_rvalid`, and holds the value the register had before the request edge. The bench drives every input at a falling edge and keeps it for exactly one rising edge. It checks `irq` at the falling edge that follows. For a read, it records the expected word at the moment it drives the request, and a monitor compares that word at the falling edge where `reg_rvalid` is seen high.

// File: rtl/ovf_irq_pkg.sv
package ovf_irq_pkg;

    // Word offsets of the register port
    typedef enum logic [2:0] {
        OFS_EN_SET  = 3'd0,
        OFS_EN_CLR  = 3'd1,
        OFS_EN_STAT = 3'd2,
        OFS_PND_CLR = 3'd3,
        OFS_PND_RAW = 3'd4
    } reg_ofs_e;

    // Read-response machine
    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;

endpackage

// File: rtl/ovf_irq_enable.sv
module ovf_irq_enable #(
    parameter int NUM_CNT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_stb,
    input  logic               clr_stb,
    input  logic [NUM_CNT-1:0] wr_bits,
    output logic [NUM_CNT-1:0] en_mask
);
    logic [NUM_CNT-1:0] en_q;
    logic [NUM_CNT-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (set_stb) en_d = en_d | wr_bits;
        if (clr_stb) en_d = en_d & ~wr_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en_mask = en_q;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_en_chk
        p_set_enables_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(set_stb) && $past(wr_bits[i])) |-> en_q[i]);
        p_clr_disables_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(clr_stb) && $past(wr_bits[i])) |-> !en_q[i]);
        p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(set_stb) && !$past(clr_stb)) |-> $stable(en_q[i]));
    end
endmodule

// File: rtl/ovf_irq_status.sv
module ovf_irq_status #(
    parameter int NUM_CNT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] pulse,
    input  logic               clr_stb,
    input  logic [NUM_CNT-1:0] wr_bits,
    output logic [NUM_CNT-1:0] pnd_mask
);
    logic [NUM_CNT-1:0] pnd_q;
    logic [NUM_CNT-1:0] clr_vec;

    // A pulse outranks a clear of the same bit at the same edge
    assign clr_vec = clr_stb ? wr_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pnd_q <= '0;
        else        pnd_q <= (pnd_q & ~clr_vec) | pulse;
    end

    assign pnd_mask = pnd_q;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_pnd_chk
        p_pulse_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(pulse[i])) |-> pnd_q[i]);
        p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(clr_stb) && $past(wr_bits[i]) && !$past(pulse[i]))
            |-> !pnd_q[i]);
        p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(pnd_q[i]) && !$past(clr_stb)) |-> pnd_q[i]);
    end
endmodule

// File: rtl/ovf_irq_regport.sv
module ovf_irq_regport
    import ovf_irq_pkg::*;
#(
    parameter int NUM_CNT  = 16,
    parameter int BIT_BASE = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_CNT-1:0] en_mask,
    input  logic [NUM_CNT-1:0] pnd_mask,
    output logic               en_set_stb,
    output logic               en_clr_stb,
    output logic               pnd_clr_stb,
    output logic [NUM_CNT-1:0] wr_bits,
    output logic [DATA_W-1:0]  rdata,
    output logic               rvalid
);
    localparam int FIELD_TOP = BIT_BASE + NUM_CNT;

    acc_state_e        state_q, state_d;
    logic [DATA_W-1:0] rdata_q, rsel;
    logic              wr_hit, rd_hit;

    assign wr_hit = req && we;
    assign rd_hit = req && !we;
    assign wr_bits = wdata[BIT_BASE +: NUM_CNT];

    assign en_set_stb  = wr_hit && (addr == ADDR_W'(OFS_EN_SET));
    assign en_clr_stb  = wr_hit && (addr == ADDR_W'(OFS_EN_CLR));
    assign pnd_clr_stb = wr_hit && (addr == ADDR_W'(OFS_PND_CLR));

    always_comb begin
        rsel = '0;
        if (addr == ADDR_W'(OFS_EN_STAT))      rsel = DATA_W'(en_mask) << BIT_BASE;
        else if (addr == ADDR_W'(OFS_PND_RAW)) rsel = DATA_W'(pnd_mask) << BIT_BASE;
    end

    // Transitions: IDLE_TO_RESP, RESP_TO_RESP, RESP_TO_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (rd_hit) state_d = ACC_RESP;
            ACC_RESP: state_d = rd_hit ? ACC_RESP : ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_hit) rdata_q <= rsel;
    end

    assign rvalid = (state_q == ACC_RESP);
    assign rdata  = rdata_q;

    initial begin
        a_field_fits_r4: assert (FIELD_TOP <= DATA_W);
    end

    p_rvalid_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> ($past(rst_n) && $past(req) && !$past(we)));
    p_read_gives_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> rvalid);
endmodule

// File: rtl/ovf_irq_unit.sv
module ovf_irq_unit #(
    parameter int NUM_CNT  = 16,
    parameter int BIT_BASE = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] ovf_pulse,
    input  logic               reg_req,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               reg_rvalid,
    output logic               irq
);
    logic               en_set_stb, en_clr_stb, pnd_clr_stb;
    logic [NUM_CNT-1:0] wr_bits, en_mask, pnd_mask;

    ovf_irq_regport #(
        .NUM_CNT(NUM_CNT), .BIT_BASE(BIT_BASE), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_port (
        .clk(clk), .rst_n(rst_n), .req(reg_req), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .en_mask(en_mask), .pnd_mask(pnd_mask),
        .en_set_stb(en_set_stb), .en_clr_stb(en_clr_stb), .pnd_clr_stb(pnd_clr_stb),
        .wr_bits(wr_bits), .rdata(reg_rdata), .rvalid(reg_rvalid)
    );

    ovf_irq_enable #(.NUM_CNT(NUM_CNT)) u_en (
        .clk(clk), .rst_n(rst_n), .set_stb(en_set_stb), .clr_stb(en_clr_stb),
        .wr_bits(wr_bits), .en_mask(en_mask)
    );

    ovf_irq_status #(.NUM_CNT(NUM_CNT)) u_pnd (
        .clk(clk), .rst_n(rst_n), .pulse(ovf_pulse), .clr_stb(pnd_clr_stb),
        .wr_bits(wr_bits), .pnd_mask(pnd_mask)
    );

    assign irq = |(pnd_mask & en_mask);

    p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask == '0) |-> !irq);
    p_irq_needs_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pnd_mask != '0));
    p_enabled_pulse_raises_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (($past(ovf_pulse) & en_mask) != '0)) |-> irq);
endmodule

// File: tb/sim_ovf_irq_unit.sv
module sim_ovf_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ovf_pulse = '0;
    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid, irq;

    int n_chk = 0, n_bad = 0;
    logic [15:0] en_m = '0, pnd_m = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    ovf_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .ovf_pulse(ovf_pulse), .reg_req(reg_req),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .irq(irq)
    );

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_model(input logic [2:0] a);
        if (a == 3'd2) return 32'(en_m) << 8;
        if (a == 3'd4) return 32'(pnd_m) << 8;
        return 32'h0;
    endfunction

    // One request and/or pulse pattern held for one rising edge
    task automatic step(input logic rq, input logic w, input logic [2:0] a,
                        input logic [31:0] d, input logic [15:0] p, input string tag);
        logic [15:0] b;
        @(negedge clk);
        reg_req = rq; reg_we = w; reg_addr = a; reg_wdata = d; ovf_pulse = p;
        if (rq && !w) begin exp_q.push_back(rd_model(a)); tag_q.push_back(tag); end
        @(posedge clk);
        b = d[23:8];
        if (rq && w) begin
            if (a == 3'd0) en_m = en_m | b;
            else if (a == 3'd1) en_m = en_m & ~b;
            else if (a == 3'd3) pnd_m = pnd_m & ~b;
        end
        pnd_m = pnd_m | p;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; ovf_pulse = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
        step(1'b1, 1'b1, a, d, 16'h0, tag);
    endtask
    task automatic rd(input logic [2:0] a, input string tag);
        step(1'b1, 1'b0, a, 32'h0, 16'h0, tag);
    endtask
    task automatic chk_irq(input string tag);
        cmp(tag, {31'h0, irq}, {31'h0, |(pnd_m & en_m)});
    endtask

    // Monitor: compares read responses against the scoreboard
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R9: actual rvalid 1 expected 0");
            end else begin
                cmp(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cmp("R1 irq", {31'h0, irq}, 32'h0);
        cmp("R1 rvalid", {31'h0, reg_rvalid}, 32'h0);
        rd(3'd2, "R1 enable mask");
        rd(3'd4, "R1 pending mask");

        // R5 pulse sets pending while disabled; R8 irq stays low
        step(1'b0, 1'b0, 3'd0, 32'h0, 16'h0008, "R5 pulse");
        chk_irq("R8 disabled pending");
        rd(3'd4, "R5 pending bit 11");

        // R2 enable counter 3 raises irq
        wr(3'd0, 32'h0000_0800, "R2 set");
        chk_irq("R8 enabled pending");
        // R2 zero bits leave others; R4 low and high bits ignored
        wr(3'd0, 32'hFF00_20FF, "R2 set c5");
        rd(3'd2, "R2 R4 enable mask");

        // R3 disable counter 3
        wr(3'd1, 32'h0000_0800, "R3 clr");
        chk_irq("R3 irq drop");
        rd(3'd2, "R3 enable mask");

        // Boundary counters 0 and 15
        wr(3'd0, 32'h0080_0100, "R2 edges");
        step(1'b0, 1'b0, 3'd0, 32'h0, 16'h8001, "R5 edges");
        chk_irq("R8 edge counters");
        rd(3'd4, "R5 edge pending");

        // R6 clear only counter 0
        wr(3'd3, 32'h0000_0100, "R6 partial");
        rd(3'd4, "R6 partial pending");

        // R7 pulse and clear together on counter 15
        step(1'b1, 1'b1, 3'd3, 32'h0080_0000, 16'h8000, "R7");
        rd(3'd4, "R7 stays set");
        chk_irq("R7 irq held");

        // R9 writes to read-only and unmapped offsets ignored
        wr(3'd2, 32'h0000_0000, "R9 ro en");
        wr(3'd4, 32'h0000_0000, "R9 ro pnd");
        wr(3'd6, 32'h00FF_FF00, "R9 unmapped");
        rd(3'd2, "R9 enable unchanged");
        rd(3'd4, "R9 pending unchanged");
        rd(3'd5, "R9 unmapped reads zero");

        // R9 back-to-back reads return pre-edge values
        step(1'b1, 1'b0, 3'd2, 32'h0, 16'h0, "R9 b2b a");
        step(1'b1, 1'b0, 3'd4, 32'h0, 16'h0040, "R9 b2b pre-pulse");
        rd(3'd4, "R9 post-pulse");

        // R6 clear all
        wr(3'd3, 32'h00FF_FFFF, "R6 all");
        rd(3'd4, "R6 all cleared");
        chk_irq("R6 R8 irq low");

        repeat (4) @(negedge clk);
        cmp("R9 queue drained", 32'(exp_q.size()), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule